// File: doc/BRIEF.md
# Binary Trinomial Field Reducer

This block turns the raw, unreduced product of two binary-field polynomials into a canonical field element. The field is GF(2^M) defined by the trinomial x^M + x^N + 1, with M = 233 and N = 74 by default. The product arrives as a 2M-1 bit vector (465 bits by default) whose bit k is the coefficient of x^k. The block returns the M-bit residue, whose degree is always below M.

The reduction uses only XOR gates. Every term x^(M+k) is rewritten as x^(N+k) + x^k. The whole upper part of the vector is folded down onto the lower part in one step, and this step is applied twice. The first fold leaves a value of at most M+N-1 bits. The second fold leaves fewer than M bits whenever 2N-1 <= M, and the parameter checks enforce that bound at elaboration.

A parameter selects the output latency: zero register stages (purely combinational) or one register stage (the default). A valid flag travels alongside the data with the same latency. A multiplier feeds the block directly and samples the result at that fixed latency.

Top module: `gf2_trinomial_reducer`

## Requirements
- R1: For any 2M-1 bit input presented with `in_valid`, `out_data` equals the input polynomial reduced modulo x^M + x^N + 1. Bit k of both vectors is the coefficient of x^k.
- R2: An input whose bits M and above are all zero appears on `out_data` unchanged in bits M-1:0.
- R3: An all-zero input gives an all-zero `out_data`.
- R4: With M=233 and N=74, the single term x^464 (only input bit 464 set) gives an output with exactly bits 231, 146 and 72 set.
- R5: An all-ones input gives the correctly reduced residue.
- R6: `out_valid` equals `in_valid` delayed by PIPE_STAGES clock cycles (1 by default), and its matching `out_data` appears in the same cycle.
- R7: With one register stage, `out_data` keeps its last value in every cycle that follows a cycle in which `in_valid` was low.
- R8: While `rst_n` is low, and afterwards until the first accepted input, `out_valid` is low. With one register stage, `out_data` is reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a product to reduce |
| in_data | input | 2*FIELD_M-1 | Unreduced product; bit k is the coefficient of x^k |
| out_valid | output | 1 | Marks `out_data` as a reduced result |
| out_data | output | FIELD_M | Canonical residue; degree below FIELD_M |

## Verification
With the default single register stage, each result is due exactly one rising edge after the edge that samples `in_valid`. The bench drives inputs on falling edges. It reads `out_valid` and `out_data` on the next falling edge, half a cycle after the capturing edge. In the cycle after that, `in_valid` is low and `in_data` carries unrelated junk. At that point the bench expects `out_valid` low and `out_data` unchanged, which covers R6 and R7. Expected residues come from a bit-serial reduction in the bench. It scans from bit 464 down to bit 233, and the x^464 case is also compared against a hand-derived constant.

// File: rtl/trinomial_pkg.sv
package trinomial_pkg;
   localparam int DEF_FIELD_M = 233;
   localparam int DEF_TAP_N   = 74;

   function automatic int prod_width(input int m);
      return 2 * m - 1;
   endfunction

   function automatic int mid_width(input int m, input int n);
      return m + n - 1;
   endfunction
endpackage

// File: rtl/trinomial_fold.sv
module trinomial_fold #(
   parameter int FIELD_M = 233,
   parameter int TAP_N   = 74,
   parameter int IN_W    = 465,
   parameter int OUT_W   = 306
) (
   input  logic [IN_W-1:0]  fold_in,
   output logic [OUT_W-1:0] fold_out
);
   localparam int HI_W = IN_W - FIELD_M;

   if (HI_W < 1) begin : g_bad_in
      $error("trinomial_fold: input must exceed the field width");
   end
   if (OUT_W < FIELD_M || OUT_W < HI_W + TAP_N) begin : g_bad_out
      $error("trinomial_fold: output too narrow for folded terms");
   end

   logic [HI_W-1:0]    upper;
   logic [OUT_W-1:0]   acc;

   assign upper = fold_in[IN_W-1:FIELD_M];

   always_comb begin
      acc = '0;
      acc[FIELD_M-1:0] = fold_in[FIELD_M-1:0];
      for (int i = 0; i < HI_W; i++) begin
         acc[i]         = acc[i] ^ upper[i];
         acc[i + TAP_N] = acc[i + TAP_N] ^ upper[i];
      end
   end

   assign fold_out = acc;
endmodule

// File: rtl/trinomial_out_stage.sv
module trinomial_out_stage #(
   parameter int WIDTH  = 233,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stg_valid_in,
   input  logic [WIDTH-1:0] stg_data_in,
   output logic             stg_valid_out,
   output logic [WIDTH-1:0] stg_data_out
);
   if (STAGES == 0) begin : g_comb
      assign stg_valid_out = stg_valid_in;
      assign stg_data_out  = stg_data_in;
   end else if (STAGES == 1) begin : g_reg
      logic             vld_q;
      logic [WIDTH-1:0] dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else begin
            vld_q <= stg_valid_in;
            if (stg_valid_in) dat_q <= stg_data_in;
         end
      end
      assign stg_valid_out = vld_q;
      assign stg_data_out  = dat_q;
   end else begin : g_bad_stages
      $error("trinomial_out_stage: STAGES must be 0 or 1");
   end
endmodule

// File: rtl/gf2_trinomial_reducer.sv
module gf2_trinomial_reducer
   import trinomial_pkg::*;
#(
   parameter int FIELD_M     = DEF_FIELD_M,
   parameter int TAP_N       = DEF_TAP_N,
   parameter int PIPE_STAGES = 1,
   localparam int PROD_W     = prod_width(FIELD_M)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PROD_W-1:0] in_data,
   output logic              out_valid,
   output logic [FIELD_M-1:0] out_data
);
   localparam int MID_W = mid_width(FIELD_M, TAP_N);

   if (TAP_N < 2 || TAP_N >= FIELD_M) begin : g_bad_tap
      $error("gf2_trinomial_reducer: TAP_N must lie in 2..FIELD_M-1");
   end
   if (2 * TAP_N - 1 > FIELD_M) begin : g_bad_two_pass
      $error("gf2_trinomial_reducer: two folds insufficient, need 2*TAP_N-1 <= FIELD_M");
   end

   logic [MID_W-1:0]   pass1_q;
   logic [FIELD_M-1:0] residue;

   trinomial_fold #(
      .FIELD_M (FIELD_M),
      .TAP_N   (TAP_N),
      .IN_W    (PROD_W),
      .OUT_W   (MID_W)
   ) i_fold_first (
      .fold_in  (in_data),
      .fold_out (pass1_q)
   );

   trinomial_fold #(
      .FIELD_M (FIELD_M),
      .TAP_N   (TAP_N),
      .IN_W    (MID_W),
      .OUT_W   (FIELD_M)
   ) i_fold_second (
      .fold_in  (pass1_q),
      .fold_out (residue)
   );

   trinomial_out_stage #(
      .WIDTH  (FIELD_M),
      .STAGES (PIPE_STAGES)
   ) i_out_stage (
      .clk           (clk),
      .rst_n         (rst_n),
      .stg_valid_in  (in_valid),
      .stg_data_in   (residue),
      .stg_valid_out (out_valid),
      .stg_data_out  (out_data)
   );
endmodule

// File: rtl/trinomial_reducer_chk.sv
module trinomial_reducer_chk #(
   parameter int FIELD_M     = 233,
   parameter int TAP_N       = 74,
   parameter int PIPE_STAGES = 1,
   parameter int PROD_W      = 465
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [PROD_W-1:0]  in_data,
   input logic               out_valid,
   input logic [FIELD_M-1:0] out_data
);
   logic upper_clear;
   assign upper_clear = (in_data[PROD_W-1:FIELD_M] == '0);

   if (PIPE_STAGES == 1) begin : g_seq
      p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid));
      p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && upper_clear) |=> (out_data == $past(in_data[FIELD_M-1:0])));
      p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_data == '0) |=> (out_data == '0));
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(out_data));
      always @(posedge clk) begin
         if (!rst_n) begin
            p_reset_idle_r8: assert (!out_valid && out_data == '0);
         end
      end
   end else begin : g_comb
      p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && upper_clear) |-> (out_data == in_data[FIELD_M-1:0]));
      p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_data == '0) |-> (out_data == '0));
      p_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |-> !out_valid);
   end
endmodule

bind gf2_trinomial_reducer trinomial_reducer_chk #(
   .FIELD_M     (FIELD_M),
   .TAP_N       (TAP_N),
   .PIPE_STAGES (PIPE_STAGES),
   .PROD_W      (PROD_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/test_gf2_trinomial_reducer.sv
`timescale 1ns/1ps
module test_gf2_trinomial_reducer;
   localparam int M  = 233;
   localparam int N  = 74;
   localparam int PW = 2 * M - 1;
   localparam int NUM_VEC = 8;
   localparam logic [63:0] SEEDS [NUM_VEC] = '{
      64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0BAD_F00D,
      64'h0000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000,
      64'h5555_AAAA_3333_CCCC, 64'h1357_9BDF_2468_ACE0,
      64'h8000_0000_0000_0000, 64'h7E57_C0DE_1234_5678 };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] in_data = '0;
   logic          out_valid;
   logic [M-1:0]  out_data;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gf2_trinomial_reducer i_gf2_trinomial_reducer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   function automatic logic [M-1:0] ref_reduce(input logic [PW-1:0] v);
      logic [PW-1:0] t = v;
      for (int i = PW - 1; i >= M; i--) begin
         if (t[i]) begin
            t[i]         = 1'b0;
            t[i - M + N] = ~t[i - M + N];
            t[i - M]     = ~t[i - M];
         end
      end
      return t[M-1:0];
   endfunction

   function automatic logic [PW-1:0] expand(input logic [63:0] seed);
      logic [63:0] s = seed;
      logic [PW-1:0] r = '0;
      for (int k = 0; k < 8; k++) begin
         s = s ^ (s << 13);
         s = s ^ (s >> 7);
         s = s ^ (s << 17);
         r = (r << 64) | PW'(s);
      end
      return r;
   endfunction

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic check_vec(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one product, check result one cycle later, then check idle/hold
   task automatic run_one(input string req, input logic [PW-1:0] d, input logic [M-1:0] exp);
      logic [M-1:0] held;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = ~d;
      check_bit({req, " R6 valid"}, out_valid, 1'b1);
      check_vec(req, out_data, exp);
      held = out_data;
      @(negedge clk);
      check_bit("R6 idle", out_valid, 1'b0);
      check_vec("R7 hold", out_data, held);
   endtask

   initial begin
      logic [M-1:0] e464;
      repeat (3) @(negedge clk);
      check_bit("R8 valid in reset", out_valid, 1'b0);
      check_vec("R8 data in reset", out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R8 valid after reset", out_valid, 1'b0);

      for (int v = 0; v < NUM_VEC; v++) begin
         logic [PW-1:0] d = expand(SEEDS[v]);
         run_one("R1 table", d, ref_reduce(d));
      end

      run_one("R3 zero", '0, '0);
      run_one("R2 passthrough", PW'(expand(64'h0F0F_1234_5678_9ABC) & {{(PW-M){1'b0}}, {M{1'b1}}}),
              expand(64'h0F0F_1234_5678_9ABC) & {{(PW-M){1'b0}}, {M{1'b1}}});
      e464 = '0;
      e464[231] = 1'b1;
      e464[146] = 1'b1;
      e464[72]  = 1'b1;
      run_one("R4 x^464", {1'b1, {(PW-1){1'b0}}}, e464);
      run_one("R5 all ones", {PW{1'b1}}, ref_reduce({PW{1'b1}}));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule